// File: doc/BRIEF.md
# Pi/4-Shift DQPSK Burst Symbol Mapper

This block turns a serial bit stream into a stream of differentially encoded pi/4-shift QPSK phase indices, framed by a burst-enable input. Both the data bit and the burst level are sampled on the rising edge of the bit clock. After an alignment point, consecutive bits are taken two at a time. Each pair is turned into a phase step. A 3-bit accumulator adds the step, modulo eight, and holds the carrier phase in units of pi/4. The phase index goes to a downstream pulse-shaping filter, with a one-cycle strobe for each symbol.

Every burst is wrapped in ramp segments. A fixed number of all-zero symbols goes out before the first data symbol and the same number after the last one. To make room for the leading ramp, the data is delayed by that many symbol slots. A delayed copy of the burst-enable input is also provided, for a transmitter switch further down the chain.

After reset, or after the power-down input is released, symbol timing is free-running and unaligned. The first rising edge of the burst input then fixes where pair boundaries fall. A test mode replaces every pair with a constant two-bit value and drops the ramps.

Top module: `pi4dq_burst_mapper`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `sym_valid` and `burst_out` are 0 and `phase_idx` is 0.
- R2: The first rising edge of `burst_in` after reset or after power-down sets the pair boundaries. The bit sampled on that edge is the first bit X of a pair, and the bit on the next edge is the second bit Y. The first symbol strobe comes right after the Y edge.
- R3: A pair written {X,Y} advances the phase index modulo 8 as follows: 2'b00 by +1, 2'b01 by +3, 2'b11 by +5 (that is, -3) and 2'b10 by +7 (that is, -1).
- R4: On the first symbol slot of every burst, the accumulator restarts from 0. In normal mode the first symbol of a burst is therefore index 1.
- R5: In normal mode, RAMP_SYMS (default 2) symbols with pair 2'b00 come before the data of each burst. Data pairs leave RAMP_SYMS slots after they arrive.
- R6: In normal mode, RAMP_SYMS symbols with pair 2'b00 follow the last data symbol of each burst. After that, no strobe appears until the next burst.
- R7: `sym_valid` is a one-cycle pulse, never high on two consecutive cycles. `phase_idx` changes only together with a strobe.
- R8: Count the edge that first samples a new `burst_in` level as edge 1. `burst_out` takes that level after edge LAG_BITS (default 5). With the input set up half a bit early, this is 2.25 symbols.
- R9: While `test_en` is 1, every data pair is replaced by `test_pair` ({X,Y}) and no ramp symbols are sent. Data slots keep their normal timing.
- R10: When the trailing ramp of one burst falls on the same slot as the leading ramp of the next, the leading ramp wins and the accumulator restarts.
- R11: While `pwr_down` is 1, no strobe is sent, `burst_out` is 0 and the data and burst inputs are ignored. After release, timing waits for the next rising edge of `burst_in` (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down: idles outputs and re-arms alignment |
| ser_bit | input | 1 | Serial data bit |
| burst_in | input | 1 | Burst enable; high for an even number of symbols |
| test_en | input | 1 | Constant-pair test mode enable |
| test_pair | input | 2 | Constant pair {X,Y} used in test mode |
| sym_valid | output | 1 | One-cycle strobe per emitted symbol |
| phase_idx | output | 3 | Current phase in units of pi/4 |
| burst_out | output | 1 | Delayed copy of burst_in |

## Verification
The case most likely to hide a fault is two bursts separated by a gap of only two symbols. The trailing ramp of the first burst and the leading ramp of the second then fall in the same slots, and the second burst's accumulator restart coincides with a ramp-down step. The bench provokes this by sending two short bursts whose first burst leaves the accumulator at 2, so a missing restart would give 3 instead of 1. It then compares the whole emitted index sequence, slot by slot, against a sequence worked out by hand from the step table and the ramp rules.

// File: rtl/pdq_pkg.sv
package pdq_pkg;

   localparam int PH_W = 3;

   typedef logic [PH_W-1:0] phase_t;
   typedef logic [1:0]      dibit_t;

   // decision for one symbol slot
   typedef struct packed {
      logic   emit;
      logic   start;
      logic   ramp;
      dibit_t sym;
   } slot_dec_t;

   // phase advance for a pair {X,Y}, in units of pi/4
   function automatic phase_t step_of(input dibit_t d);
      phase_t s;
      case (d)
         2'b00:   s = phase_t'(1);
         2'b01:   s = phase_t'(3);
         2'b11:   s = phase_t'(5);
         default: s = phase_t'(7);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pdq_bit_aligner.sv
module pdq_bit_aligner
   import pdq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pwr_down,
   input  logic   ser_bit,
   input  logic   burst_in,
   output logic   slot_vld,
   output dibit_t slot_pair,
   output logic   slot_burst
);

   logic armed_q;
   logic odd_q;
   logic prev_q;
   logic x_q;
   logic b_q;
   logic align_hit;

   assign align_hit = armed_q & burst_in & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         odd_q   <= 1'b0;
         prev_q  <= 1'b0;
         x_q     <= 1'b0;
         b_q     <= 1'b0;
      end else if (pwr_down) begin
         armed_q <= 1'b1;
         odd_q   <= 1'b0;
         prev_q  <= 1'b0;
         b_q     <= 1'b0;
      end else begin
         prev_q <= burst_in;
         if (align_hit) begin
            armed_q <= 1'b0;
            odd_q   <= 1'b1;
            x_q     <= ser_bit;
            b_q     <= 1'b1;
         end else if (!odd_q) begin
            odd_q <= 1'b1;
            x_q   <= ser_bit;
            b_q   <= burst_in & ~armed_q;
         end else begin
            odd_q <= 1'b0;
         end
      end
   end

   assign slot_vld   = odd_q & ~pwr_down;
   assign slot_pair  = {x_q, ser_bit};
   assign slot_burst = b_q;

endmodule

// File: rtl/pdq_burst_framer.sv
module pdq_burst_framer
   import pdq_pkg::*;
#(
   parameter int RAMP_SYMS = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_down,
   input  logic      slot_vld,
   input  dibit_t    slot_pair,
   input  logic      slot_burst,
   input  logic      test_en,
   input  dibit_t    test_pair,
   output logic      dec_vld,
   output slot_dec_t dec
);

   localparam int HD = 2 * RAMP_SYMS;

   logic [HD:1] bh_q;
   dibit_t      pq_q [1:RAMP_SYMS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bh_q <= '0;
      else if (pwr_down)   bh_q <= '0;
      else if (slot_vld)   bh_q <= {bh_q[HD-1:1], slot_burst};
   end

   for (genvar k = 1; k <= RAMP_SYMS; k++) begin : g_pair_dly
      if (k == 1) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pq_q[k] <= '0;
            else if (slot_vld) pq_q[k] <= slot_pair;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pq_q[k] <= '0;
            else if (slot_vld) pq_q[k] <= pq_q[k-1];
         end
      end
   end

   logic data_slot;
   logic tail_slot;
   logic ramp_slot;

   assign data_slot = bh_q[RAMP_SYMS];
   assign tail_slot = |bh_q[HD:RAMP_SYMS+1];
   assign ramp_slot = ~test_en & ~data_slot & (slot_burst | tail_slot);

   always_comb begin
      dec.start = slot_burst & ~bh_q[1];
      dec.ramp  = ramp_slot;
      dec.emit  = data_slot | ramp_slot;
      if (ramp_slot)    dec.sym = 2'b00;
      else if (test_en) dec.sym = test_pair;
      else              dec.sym = pq_q[RAMP_SYMS];
   end

   assign dec_vld = slot_vld;

endmodule

// File: rtl/pdq_phase_accum.sv
module pdq_phase_accum
   import pdq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_down,
   input  logic      dec_vld,
   input  slot_dec_t dec,
   output logic      sym_valid,
   output phase_t    phase_idx
);

   phase_t acc_q;
   phase_t base;
   phase_t nxt;

   assign base = dec.start ? '0 : acc_q;
   assign nxt  = base + step_of(dec.sym);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         phase_idx <= '0;
         sym_valid <= 1'b0;
      end else if (pwr_down) begin
         acc_q     <= '0;
         sym_valid <= 1'b0;
      end else if (dec_vld && dec.emit) begin
         acc_q     <= nxt;
         phase_idx <= nxt;
         sym_valid <= 1'b1;
      end else begin
         if (dec_vld) acc_q <= base;
         sym_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/pdq_lag_line.sv
module pdq_lag_line #(
   parameter int DEPTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic dout
);

   if (DEPTH == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   r_q <= 1'b0;
         else if (clr) r_q <= 1'b0;
         else          r_q <= din;
      end
      assign dout = r_q;
   end else begin : g_chain
      logic [DEPTH-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sr_q <= '0;
         else if (clr) sr_q <= '0;
         else          sr_q <= {sr_q[DEPTH-2:0], din};
      end
      assign dout = sr_q[DEPTH-1];
   end

endmodule

// File: rtl/pi4dq_burst_mapper.sv
module pi4dq_burst_mapper
   import pdq_pkg::*;
#(
   parameter int RAMP_SYMS = 2,
   parameter int LAG_BITS  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_down,
   input  logic       ser_bit,
   input  logic       burst_in,
   input  logic       test_en,
   input  logic [1:0] test_pair,
   output logic       sym_valid,
   output logic [2:0] phase_idx,
   output logic       burst_out
);

   if (RAMP_SYMS < 1 || RAMP_SYMS > 8) begin : g_bad_ramp
      $error("RAMP_SYMS must lie in 1..8");
   end
   if (LAG_BITS < 1) begin : g_bad_lag
      $error("LAG_BITS must be at least 1");
   end

   logic      slot_vld;
   dibit_t    slot_pair;
   logic      slot_burst;
   logic      dec_vld;
   slot_dec_t dec;
   phase_t    ph;

   pdq_bit_aligner u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_down   (pwr_down),
      .ser_bit    (ser_bit),
      .burst_in   (burst_in),
      .slot_vld   (slot_vld),
      .slot_pair  (slot_pair),
      .slot_burst (slot_burst)
   );

   pdq_burst_framer #(.RAMP_SYMS(RAMP_SYMS)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_down   (pwr_down),
      .slot_vld   (slot_vld),
      .slot_pair  (slot_pair),
      .slot_burst (slot_burst),
      .test_en    (test_en),
      .test_pair  (test_pair),
      .dec_vld    (dec_vld),
      .dec        (dec)
   );

   pdq_phase_accum u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_down  (pwr_down),
      .dec_vld   (dec_vld),
      .dec       (dec),
      .sym_valid (sym_valid),
      .phase_idx (ph)
   );

   assign phase_idx = ph;

   pdq_lag_line #(.DEPTH(LAG_BITS)) u_lag (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pwr_down),
      .din   (burst_in),
      .dout  (burst_out)
   );

endmodule

// File: rtl/pdq_mapper_chk.sv
module pdq_mapper_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_down,
   input logic       dec_vld,
   input logic       dec_start,
   input logic       dec_ramp,
   input logic       dec_emit,
   input logic       sym_valid,
   input logic [2:0] phase_idx,
   input logic       burst_out
);

   // R7
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |=> !sym_valid);

   // R7
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid |-> $stable(phase_idx));

   // R4
   burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_start && dec_emit) |=> (sym_valid && phase_idx == 3'd1));

   // R5 R6
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_ramp && !dec_start) |=>
         (sym_valid && phase_idx == $past(phase_idx) + 3'd1));

   // R11
   pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (!sym_valid && !burst_out));

endmodule

bind pi4dq_burst_mapper pdq_mapper_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_down  (pwr_down),
   .dec_vld   (dec_vld),
   .dec_start (dec.start),
   .dec_ramp  (dec.ramp),
   .dec_emit  (dec.emit),
   .sym_valid (sym_valid),
   .phase_idx (phase_idx),
   .burst_out (burst_out)
);

// File: tb/tb_pi4dq_burst_mapper.sv
module tb_pi4dq_burst_mapper;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_down = 1'b0;
   logic       ser_bit = 1'b0;
   logic       burst_in = 1'b0;
   logic       test_en = 1'b0;
   logic [1:0] test_pair = 2'b00;
   logic       sym_valid;
   logic [2:0] phase_idx;
   logic       burst_out;

   pi4dq_burst_mapper dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_down  (pwr_down),
      .ser_bit   (ser_bit),
      .burst_in  (burst_in),
      .test_en   (test_en),
      .test_pair (test_pair),
      .sym_valid (sym_valid),
      .phase_idx (phase_idx),
      .burst_out (burst_out)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int tick_n = 0;
   int bo_rise = -1;
   int bo_fall = -1;
   int bo_high_cnt = 0;
   logic bo_last = 1'b0;
   int got_q [$];
   int vt_q  [$];
   int exp_q [$];
   logic [1:0] pat [8];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic b, input logic bu);
      ser_bit  = b;
      burst_in = bu;
      @(posedge clk);
      @(negedge clk);
      tick_n++;
      if (sym_valid) begin
         got_q.push_back(int'(phase_idx));
         vt_q.push_back(tick_n);
      end
      if (burst_out) bo_high_cnt++;
      if (burst_out && !bo_last) bo_rise = tick_n;
      if (!burst_out && bo_last) bo_fall = tick_n;
      bo_last = burst_out;
   endtask

   task automatic send_pairs(input int n, input logic bu);
      for (int k = 0; k < n; k++) begin
         tick(pat[k][1], bu);
         tick(pat[k][0], bu);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) tick(k[0], 1'b0);
   endtask

   function automatic int step_val(input logic [1:0] p);
      case (p)
         2'b00:   return 1;
         2'b01:   return 3;
         2'b11:   return 5;
         default: return 7;
      endcase
   endfunction

   // expected indices of one isolated burst built from the step table
   task automatic build_exp(input int n, input bit ramps, input bit use_tp);
      int acc = 0;
      exp_q.delete();
      if (ramps) for (int k = 0; k < 2; k++) begin acc = (acc + 1) % 8; exp_q.push_back(acc); end
      for (int k = 0; k < n; k++) begin
         acc = (acc + step_val(use_tp ? test_pair : pat[k])) % 8;
         exp_q.push_back(acc);
      end
      if (ramps) for (int k = 0; k < 2; k++) begin acc = (acc + 1) % 8; exp_q.push_back(acc); end
   endtask

   task automatic cmp_seq(input string req);
      check(got_q.size() == exp_q.size(), req, "symbol count", got_q.size(), exp_q.size());
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
         check(got_q[k] == exp_q[k], req, $sformatf("phase of symbol %0d", k), got_q[k], exp_q[k]);
      for (int k = 1; k < vt_q.size(); k++)
         check(vt_q[k] - vt_q[k-1] == 2, "R7", "strobe spacing", vt_q[k] - vt_q[k-1], 2);
   endtask

   task automatic clear_log();
      got_q.delete();
      vt_q.delete();
      bo_rise = -1;
      bo_fall = -1;
      bo_high_cnt = 0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(sym_valid == 1'b0, "R1", "sym_valid in reset", sym_valid, 0);
      check(phase_idx == 3'd0, "R1", "phase_idx in reset", phase_idx, 0);
      check(burst_out == 1'b0, "R1", "burst_out in reset", burst_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sym_valid == 1'b0 && burst_out == 1'b0 && phase_idx == 3'd0,
            "R1", "outputs after reset", {sym_valid, burst_out, phase_idx}, 0);
   endtask

   // R2 R3 R4 R5 R6 R8: one normal burst
   task automatic t_normal_burst();
      int i0;
      clear_log();
      idle(3);
      check(got_q.size() == 0, "R2", "strobes before alignment", got_q.size(), 0);
      pat[0] = 2'b00; pat[1] = 2'b01; pat[2] = 2'b11; pat[3] = 2'b10;
      i0 = tick_n + 1;
      send_pairs(4, 1'b1);
      idle(12);
      build_exp(4, 1'b1, 1'b0);
      cmp_seq("R3 R5 R6");
      check(vt_q.size() > 0 && vt_q[0] == i0 + 1, "R2", "first strobe tick",
            vt_q.size() > 0 ? vt_q[0] : -1, i0 + 1);
      check(got_q.size() > 0 && got_q[0] == 1, "R4", "first index of burst",
            got_q.size() > 0 ? got_q[0] : -1, 1);
      check(bo_rise == i0 + 4, "R8", "burst_out rise tick", bo_rise, i0 + 4);
      check(bo_fall == i0 + 12, "R8", "burst_out fall tick", bo_fall, i0 + 12);
   endtask

   // R9: constant pair test mode, no ramps
   task automatic t_test_mode();
      int i0;
      clear_log();
      test_en = 1'b1;
      test_pair = 2'b01;
      pat[0] = 2'b11; pat[1] = 2'b10; pat[2] = 2'b00; pat[3] = 2'b11;
      i0 = tick_n + 1;
      send_pairs(4, 1'b1);
      idle(12);
      build_exp(4, 1'b0, 1'b1);
      cmp_seq("R9");
      check(vt_q.size() > 0 && vt_q[0] == i0 + 5, "R9", "first data strobe tick",
            vt_q.size() > 0 ? vt_q[0] : -1, i0 + 5);
      test_en = 1'b0;
      test_pair = 2'b00;
   endtask

   // R10: trailing ramp of burst A meets leading ramp of burst B
   task automatic t_ramp_collision();
      clear_log();
      pat[0] = 2'b11; pat[1] = 2'b01;
      send_pairs(2, 1'b1);
      idle(4);
      pat[0] = 2'b01; pat[1] = 2'b10;
      send_pairs(2, 1'b1);
      idle(12);
      // A: ramps 1,2 then +5 -> 7, +3 -> 2; B restarts: 1,2, +3 -> 5, +7 -> 4, ramps 5,6
      exp_q.delete();
      exp_q = '{1, 2, 7, 2, 1, 2, 5, 4, 5, 6};
      cmp_seq("R10");
   endtask

   // R11: power-down idles outputs and re-arms alignment
   task automatic t_power_down();
      int i0;
      clear_log();
      pwr_down = 1'b1;
      for (int k = 0; k < 6; k++) tick(k[0], 1'b1);
      check(got_q.size() == 0, "R11", "strobes during power-down", got_q.size(), 0);
      check(bo_high_cnt == 0, "R11", "burst_out cycles during power-down", bo_high_cnt, 0);
      pwr_down = 1'b0;
      idle(3);
      check(bo_high_cnt == 0, "R11", "burst_out after release", bo_high_cnt, 0);
      pat[0] = 2'b10; pat[1] = 2'b10;
      i0 = tick_n + 1;
      send_pairs(2, 1'b1);
      idle(12);
      build_exp(2, 1'b1, 1'b0);
      cmp_seq("R11");
      check(vt_q.size() > 0 && vt_q[0] == i0 + 1, "R11", "realigned first strobe tick",
            vt_q.size() > 0 ? vt_q[0] : -1, i0 + 1);
   endtask

   initial begin
      t_reset();
      t_normal_burst();
      t_test_mode();
      t_ramp_collision();
      t_power_down();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog run did not finish actual=%0d expected=0", tick_n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule